// File: doc/BRIEF.md
# Maskable Write-One-To-Clear Interrupt Controller

This block gathers single-cycle event pulses from internal sources into a bank of sticky status flags. It drives one active-low interrupt request line. Each source has a configuration bit. A build parameter selects, per source, what that bit means. In mask sense a set bit keeps the flag out of the summary. In enable sense a set bit lets the flag into the summary.

A read-only summary bit is high while any contributing flag is pending. The request line falls when the summary is high and a global enable is on. The line comes from a flop, so it changes one clock after its cause. Software clears a flag by writing a one to its position in the status register. It sets the configuration bits and the global enable through the same simple write/read port.

Register select codes on `addr_i`:
- 0 is the status register.
- 1 is the configuration register.
- 2 is the control register: bit 0 is the global enable, bit 1 is the summary.
- 3 reads as zero and ignores writes.

Top module: `irq_ctrl_top`

## Requirements
- R1: A one on `evt_i[i]` at a clock edge sets status flag i. The flag then stays set until software clears it.
- R2: A write to status (code 0) clears every flag whose `wdata_i` bit is 1. Flags at positions written with 0 are left unchanged.
- R3: If an event on a bit arrives in the same cycle as a clearing write to that bit, the flag stays set.
- R4: For a mask-sense source (`SENSE_EN[i]`=0), configuration bit i set to 1 keeps flag i out of the summary. The flag itself still reads back as set in status.
- R5: For an enable-sense source (`SENSE_EN[i]`=1), flag i reaches the summary only while configuration bit i is 1.
- R6: The summary (control bit 1) cannot be written. It stays 1 until every contributing flag is cleared, then reads 0.
- R7: `irq_no` is driven low one clock after the summary and the global enable (control bit 0) are both 1. It is otherwise high.
- R8: Reset clears all flags, all configuration bits and the global enable. During and after reset `irq_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event set pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for both read and write |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data for the register selected by `addr_i` (combinational) |
| irq_no | output | 1 | Registered interrupt request, active low |

## Verification
The bench builds the block with six sources. The top two sources use enable sense and the lower four use mask sense. The width is therefore not a power of two, and both meanings of the configuration bit are present in one register. This lets a single run cover several cases: a masked flag that stays visible in status, an enable-sense flag held back by a zero enable bit, and partial clears that leave the summary up. The pin is checked one cycle after each change of summary or global enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_GIE_BIT = 0;
  localparam int unsigned CTRL_SUM_BIT = 1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned       NUM_SRC  = 8,
  parameter logic [NUM_SRC-1:0] SENSE_EN = '0
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] cfg_i,
  output logic               summary_o
);
  logic [NUM_SRC-1:0] pass;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pass
    if (SENSE_EN[i]) begin : g_en
      assign pass[i] = cfg_i[i];
    end else begin : g_mask
      assign pass[i] = ~cfg_i[i];
    end
  end

  assign summary_o = |(flag_i & pass);
endmodule

// File: rtl/irq_pin_reg.sv
module irq_pin_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic summary_i,
  input  logic gie_i,
  output logic irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~(summary_i & gie_i);
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int unsigned        NUM_SRC  = 8,
  parameter logic [NUM_SRC-1:0] SENSE_EN = 8'hF0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_no
);
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] cfg;
  logic [NUM_SRC-1:0] clr;
  logic               gie;
  logic               summary;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(addr_i);
  assign clr = (wr_en_i && sel == SEL_STATUS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg <= '0;
      gie <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == SEL_CFG)  cfg <= wdata_i;
      if (sel == SEL_CTRL) gie <= wdata_i[CTRL_GIE_BIT];
    end
  end

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flags)
  );

  irq_gate #(.NUM_SRC(NUM_SRC), .SENSE_EN(SENSE_EN)) u_gate (
    .flag_i    (flags),
    .cfg_i     (cfg),
    .summary_o (summary)
  );

  irq_pin_reg u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .summary_i (summary),
    .gie_i     (gie),
    .irq_no    (irq_no)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_STATUS: rdata_o = flags;
      SEL_CFG:    rdata_o = cfg;
      SEL_CTRL: begin
        rdata_o[CTRL_GIE_BIT] = gie;
        rdata_o[CTRL_SUM_BIT] = summary;
      end
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               wr_en_i,
  input logic [1:0]         addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] flags_i,
  input logic               summary_i,
  input logic               gie_i,
  input logic               irq_no
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (addr_i == 2'd0);

  assert_flag_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_i & $past(evt_i)) == $past(evt_i)));

  assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((flags_i & $past(wdata_i & ~evt_i)) == '0));

  assert_evt_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && |(wdata_i & evt_i)) |=> ((flags_i & $past(wdata_i & evt_i)) == $past(wdata_i & evt_i)));

  assert_summary_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_i |-> (flags_i != '0));

  assert_pin_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_no == !($past(summary_i) && $past(gie_i))));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .flags_i   (flags),
  .summary_i (summary),
  .gie_i     (gie),
  .irq_no    (irq_no)
);

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
  localparam int unsigned N = 6;
  localparam logic [N-1:0] SENSE = 6'b110000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   addr_i = 2'd0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         irq_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_ctrl_top #(.NUM_SRC(N), .SENSE_EN(SENSE)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    rd(2'd0, d); chk("R8 status after reset", d, 0);
    rd(2'd1, d); chk("R8 cfg after reset", d, 0);
    rd(2'd2, d); chk("R8 ctrl after reset", d, 0);
    chk("R8 pin after reset", irq_no, 1);
  endtask

  task automatic t_set_and_pin();
    logic [N-1:0] d;
    pulse(6'b000001);
    settle();
    rd(2'd0, d); chk("R1 flag set and held", d, 6'b000001);
    rd(2'd2, d); chk("R6 summary up, gie off", d, 6'b000010);
    chk("R7 pin high while gie off", irq_no, 1);
    wr(2'd2, 6'b000001);
    chk("R7 pin not yet low", irq_no, 1);
    settle();
    chk("R7 pin low one cycle after gie", irq_no, 0);
  endtask

  task automatic t_w1c();
    logic [N-1:0] d;
    wr(2'd0, 6'b111110);
    rd(2'd0, d); chk("R2 zero write leaves flag", d, 6'b000001);
    wr(2'd0, 6'b000001);
    rd(2'd0, d); chk("R2 one write clears flag", d, 0);
    rd(2'd2, d); chk("R6 summary drops", d, 6'b000001);
    settle();
    chk("R7 pin released", irq_no, 1);
  endtask

  task automatic t_collision();
    logic [N-1:0] d;
    @(negedge clk_i);
    evt_i = 6'b000100; addr_i = 2'd0; wdata_i = 6'b000100; wr_en_i = 1'b1;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0; wdata_i = '0;
    rd(2'd0, d); chk("R3 event wins over clear", d, 6'b000100);
    wr(2'd0, 6'b000100);
    rd(2'd0, d); chk("R3 later clear works", d, 0);
  endtask

  task automatic t_mask();
    logic [N-1:0] d;
    wr(2'd1, 6'b001000);
    pulse(6'b001000);
    settle();
    rd(2'd0, d); chk("R4 masked flag visible", d, 6'b001000);
    rd(2'd2, d); chk("R4 masked flag no summary", d, 6'b000001);
    chk("R4 pin high while masked", irq_no, 1);
    wr(2'd1, 6'b000000);
    rd(2'd2, d); chk("R4 unmask raises summary", d, 6'b000011);
    settle();
    chk("R4 pin low after unmask", irq_no, 0);
    wr(2'd0, 6'b001000);
    settle();
  endtask

  task automatic t_enable();
    logic [N-1:0] d;
    pulse(6'b010000);
    settle();
    rd(2'd0, d); chk("R5 enable-sense flag set", d, 6'b010000);
    rd(2'd2, d); chk("R5 disabled source no summary", d, 6'b000001);
    chk("R5 pin high while disabled", irq_no, 1);
    wr(2'd1, 6'b010000);
    rd(2'd2, d); chk("R5 enabled source summary", d, 6'b000011);
    settle();
    chk("R5 pin low when enabled", irq_no, 0);
    wr(2'd2, 6'b000001);
    rd(2'd2, d); chk("R6 summary not writable", d, 6'b000011);
    wr(2'd0, 6'b010000);
    wr(2'd1, 6'b000000);
  endtask

  task automatic t_partial();
    logic [N-1:0] d;
    pulse(6'b000011);
    wr(2'd0, 6'b000001);
    rd(2'd2, d); chk("R6 summary held by remaining flag", d, 6'b000011);
    wr(2'd0, 6'b000010);
    rd(2'd2, d); chk("R6 summary clear when all cleared", d, 6'b000001);
  endtask

  task automatic t_reset_mid();
    logic [N-1:0] d;
    wr(2'd1, 6'b101010);
    pulse(6'b000101);
    settle();
    chk("R8 pin low before reset", irq_no, 0);
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk("R8 pin high in reset", irq_no, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    rd(2'd0, d); chk("R8 flags cleared", d, 0);
    rd(2'd1, d); chk("R8 cfg cleared", d, 0);
    rd(2'd2, d); chk("R8 gie cleared", d, 0);
  endtask

  initial begin
    #20_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    settle();
    t_reset();
    t_set_and_pin();
    t_w1c();
    t_collision();
    t_mask();
    t_enable();
    t_partial();
    t_reset_mid();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule